// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block holds the state of a single processor's 256 interrupt vectors and chooses which one it offers to the core. For each vector it keeps three bits: one for pending, one for in-service and one for level trigger. It also holds a programmable task priority. From that task priority and the most urgent vector in service, it derives a processor priority. Vectors are ranked in classes of sixteen, and the class is the upper nibble of the vector number. A pending vector reaches the core only when its class is strictly above the processor priority.

Interrupt sources present a vector and a trigger kind on the accept port and learn in the same cycle whether the request was taken. The core reads the offered vector and strobes an acknowledge. Later it strobes an end-of-interrupt. The block then retires the most urgent in-service vector and reports that vector, with the trigger kind that was recorded for it, on a one-cycle notification. The task priority can be written as a full byte. It can also be written and read as a 4-bit class through a narrow port.

Top module: `ivec_ctrl`

## Requirements
- R1: After reset all pending, in-service and trigger bits are clear and the task priority is 0. `irq_valid` is 0, `proc_prio` is 0, `cr_rdata` is 0 and `eoi_valid` is 0.
- R2: When any vector is pending and may be offered, `irq_vector` is the highest-numbered pending vector across all 256, whichever 32-bit word holds it (vector v sits in word v/32 at bit v mod 32). The offer appears the cycle after the accept.
- R3: `proc_prio` equals the task priority when task_priority[7:4] >= the upper nibble of the highest in-service vector, with an empty in-service set counting as vector 0. Otherwise it equals that vector with its low nibble cleared.
- R4: `irq_valid` is 1 only when `enable` is 1, some vector is pending, and (highest pending AND 0xF0) > `proc_prio` as an unsigned 8-bit comparison.
- R5: An `ack` while `irq_valid` is 1 moves the offered vector from pending to in-service. `proc_prio` and the offer reflect the change in the next cycle.
- R6: An `eoi` while some vector is in service clears the highest in-service vector and its trigger bit. In the next cycle, `eoi_valid` pulses for one cycle with `eoi_vector` set to that vector and `eoi_level` set to its trigger bit (1 = level, 0 = edge). `proc_prio` is recomputed.
- R7: An `eoi` with nothing in service produces no `eoi_valid` pulse and changes no priority.
- R8: `acc_ok` is 1 exactly when `acc_valid` is 1, `enable` is 1 and the vector is not already pending. A refused request changes no pending bit.
- R9: Each taken request overwrites the vector's trigger bit: `acc_level` 1 sets it and 0 clears it, even while that vector is in service.
- R10: A write on the narrow port (`cr_wr`) sets the task priority to {`cr_wdata`, 4'b0000}. `cr_rdata` always shows task_priority[7:4]. When `tpr_wr` and `cr_wr` are both strobed in one cycle, the full byte write wins.
- R11: An `ack` while `irq_valid` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enabled; gates acceptance and offering |
| acc_valid | input | 1 | Fixed-mode interrupt request strobe |
| acc_vector | input | 8 | Requested vector |
| acc_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| acc_ok | output | 1 | Request taken this cycle |
| ack | input | 1 | Core acknowledges the offered vector |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_wr | input | 1 | Full task priority write strobe |
| tpr_wdata | input | 8 | Full task priority value |
| cr_wr | input | 1 | Narrow (class) task priority write strobe |
| cr_wdata | input | 4 | Class value for bits 7:4 |
| cr_rdata | output | 4 | Task priority bits 7:4 |
| irq_valid | output | 1 | An interrupt is offered |
| irq_vector | output | 8 | Offered vector |
| proc_prio | output | 8 | Derived processor priority |
| eoi_valid | output | 1 | End-of-interrupt notification pulse |
| eoi_vector | output | 8 | Retired vector |
| eoi_level | output | 1 | Retired vector's trigger bit |

## Verification
A stale or misplaced in-service bit shows up one cycle after an acknowledge or end-of-interrupt. It appears as a wrong `proc_prio`, as an offer that is withheld or leaks through, or as an `eoi_vector` naming the wrong vector. A lost or misplaced trigger bit appears only much later, on the `eoi_level` of the retirement that reads it. For that reason, expected notifications are queued when the end-of-interrupt is driven and matched when the pulse arrives. A pending bit set in the wrong word shows up at once as a wrong `irq_vector` when the test vectors straddle word boundaries.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
    localparam int VEC_COUNT = 256;
    localparam int VEC_W     = $clog2(VEC_COUNT);
    localparam int WORD_BITS = 32;
    localparam int CLASS_LSB = 4;

    typedef struct packed {
        logic [VEC_COUNT-1:0] pend;
        logic [VEC_COUNT-1:0] isr;
        logic [VEC_COUNT-1:0] tmr;
        logic [VEC_W-1:0]     tpr;
        logic                 eoi_v;
        logic [VEC_W-1:0]     eoi_vec;
        logic                 eoi_lvl;
    } ivec_state_t;
endpackage

// File: rtl/ivec_top_find.sv
module ivec_top_find #(
    parameter int WIDTH  = 256,
    parameter int WORD_W = 32
) (
    input  logic [WIDTH-1:0]         bits,
    output logic                     found,
    output logic [$clog2(WIDTH)-1:0] index
);
    localparam int NWORD = WIDTH / WORD_W;
    localparam int IW    = $clog2(WIDTH);
    localparam int BW    = $clog2(WORD_W);

    function automatic logic [BW-1:0] top_bit(input logic [WORD_W-1:0] x);
        logic [BW-1:0] r;
        r = '0;
        for (int b = 0; b < WORD_W; b++) begin
            if (x[b]) r = BW'(b);
        end
        return r;
    endfunction

    logic [NWORD-1:0] word_any;
    logic [BW-1:0]    word_bit [NWORD];

    for (genvar w = 0; w < NWORD; w++) begin : g_word
        assign word_any[w] = |bits[w*WORD_W +: WORD_W];
        assign word_bit[w] = top_bit(bits[w*WORD_W +: WORD_W]);
    end

    always_comb begin
        found = |word_any;
        index = '0;
        for (int w = 0; w < NWORD; w++) begin
            if (word_any[w]) index = IW'(w * WORD_W + int'(word_bit[w]));
        end
    end
endmodule

// File: rtl/ivec_prio_merge.sv
module ivec_prio_merge #(
    parameter int PW  = 8,
    parameter int LSB = 4
) (
    input  logic [PW-1:0] tpr,
    input  logic          isr_found,
    input  logic [PW-1:0] isr_top,
    output logic [PW-1:0] ppr
);
    logic [PW-1:0] isrv;

    always_comb begin
        isrv = isr_found ? isr_top : '0;
        if (tpr[PW-1:LSB] >= isrv[PW-1:LSB]) ppr = tpr;
        else                                 ppr = {isrv[PW-1:LSB], {LSB{1'b0}}};
    end
endmodule

// File: rtl/ivec_ctrl.sv
module ivec_ctrl
    import ivec_pkg::*;
#(
    parameter int WORD_W = ivec_pkg::WORD_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             acc_valid,
    input  logic [VEC_W-1:0] acc_vector,
    input  logic             acc_level,
    output logic             acc_ok,
    input  logic             ack,
    input  logic             eoi,
    input  logic             tpr_wr,
    input  logic [VEC_W-1:0] tpr_wdata,
    input  logic             cr_wr,
    input  logic [3:0]       cr_wdata,
    output logic [3:0]       cr_rdata,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector,
    output logic [VEC_W-1:0] proc_prio,
    output logic             eoi_valid,
    output logic [VEC_W-1:0] eoi_vector,
    output logic             eoi_level
);
    localparam int CLS_W = VEC_W - CLASS_LSB;

    ivec_state_t st_d, st_q;

    logic             pend_found, isr_found;
    logic [VEC_W-1:0] pend_top, isr_top;
    logic             offer;

    ivec_top_find #(.WIDTH(VEC_COUNT), .WORD_W(WORD_W)) u_pend_find (
        .bits (st_q.pend),
        .found(pend_found),
        .index(pend_top)
    );

    ivec_top_find #(.WIDTH(VEC_COUNT), .WORD_W(WORD_W)) u_isr_find (
        .bits (st_q.isr),
        .found(isr_found),
        .index(isr_top)
    );

    ivec_prio_merge #(.PW(VEC_W), .LSB(CLASS_LSB)) u_prio (
        .tpr      (st_q.tpr),
        .isr_found(isr_found),
        .isr_top  (isr_top),
        .ppr      (proc_prio)
    );

    assign offer  = enable && pend_found &&
                    ({pend_top[VEC_W-1:CLASS_LSB], {CLASS_LSB{1'b0}}} > proc_prio);
    assign acc_ok = acc_valid && enable && !st_q.pend[acc_vector];

    always_comb begin
        st_d       = st_q;
        st_d.eoi_v = 1'b0;
        if (tpr_wr)     st_d.tpr = tpr_wdata;
        else if (cr_wr) st_d.tpr = {cr_wdata, {CLASS_LSB{1'b0}}};
        if (eoi && isr_found) begin
            st_d.isr[isr_top] = 1'b0;
            st_d.tmr[isr_top] = 1'b0;
            st_d.eoi_v        = 1'b1;
            st_d.eoi_vec      = isr_top;
            st_d.eoi_lvl      = st_q.tmr[isr_top];
        end
        if (ack && offer) begin
            st_d.isr[pend_top]  = 1'b1;
            st_d.pend[pend_top] = 1'b0;
        end
        if (acc_ok) begin
            st_d.pend[acc_vector] = 1'b1;
            st_d.tmr[acc_vector]  = acc_level;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cr_rdata   = st_q.tpr[VEC_W-1:VEC_W-CLS_W];
    assign irq_valid  = offer;
    assign irq_vector = pend_top;
    assign eoi_valid  = st_q.eoi_v;
    assign eoi_vector = st_q.eoi_vec;
    assign eoi_level  = st_q.eoi_lvl;

    assert_ppr_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        proc_prio >= st_q.tpr);

    assert_ack_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_valid) |=> (st_q.isr[$past(irq_vector)] && !st_q.pend[$past(irq_vector)]));

    assert_eoi_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && st_q.isr == '0) |=> !eoi_valid);

    assert_accept_pends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok |=> st_q.pend[$past(acc_vector)]);

    assert_class_port_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_wr && !tpr_wr) |=> (cr_rdata == $past(cr_wdata)));
endmodule

// File: tb/ivec_ctrl_test.sv
module ivec_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       acc_valid = 1'b0;
    logic [7:0] acc_vector = '0;
    logic       acc_level = 1'b0;
    logic       acc_ok;
    logic       ack = 1'b0;
    logic       eoi = 1'b0;
    logic       tpr_wr = 1'b0;
    logic [7:0] tpr_wdata = '0;
    logic       cr_wr = 1'b0;
    logic [3:0] cr_wdata = '0;
    logic [3:0] cr_rdata;
    logic       irq_valid;
    logic [7:0] irq_vector;
    logic [7:0] proc_prio;
    logic       eoi_valid;
    logic [7:0] eoi_vector;
    logic       eoi_level;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [8:0] exp_q[$];

    always #10 clk = ~clk;

    ivec_ctrl uut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        acc_valid = 0; ack = 0; eoi = 0; tpr_wr = 0; cr_wr = 0;
    endtask

    task automatic accept(input logic [7:0] v, input logic lvl, input bit exp_ok, input string tag);
        acc_valid = 1; acc_vector = v; acc_level = lvl;
        #1;
        chk(acc_ok == exp_ok, tag, acc_ok, exp_ok);
        tick();
    endtask

    task automatic retire(input bit expect_one, input logic [7:0] v, input logic lvl);
        if (expect_one) exp_q.push_back({lvl, v});
        eoi = 1;
        tick();
    endtask

    task automatic offer_is(input bit vld, input logic [7:0] v, input string tag);
        chk(irq_valid == vld, tag, irq_valid, vld);
        if (vld) chk(irq_vector == v, tag, irq_vector, v);
    endtask

    always @(negedge clk) begin
        if (eoi_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected eoi", eoi_vector, 0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk(eoi_vector == e[7:0], "R6 eoi vector", eoi_vector, e[7:0]);
                chk(eoi_level == e[8], "R9 eoi level", eoi_level, e[8]);
            end
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();
        // R1 reset state
        chk(irq_valid == 0, "R1 irq_valid", irq_valid, 0);
        chk(proc_prio == 0, "R1 proc_prio", proc_prio, 0);
        chk(cr_rdata == 0, "R1 cr_rdata", cr_rdata, 0);
        chk(eoi_valid == 0, "R1 eoi_valid", eoi_valid, 0);

        enable = 1;
        accept(8'h45, 0, 1, "R8 accept 45");
        offer_is(1, 8'h45, "R2 offer 45");
        accept(8'h45, 1, 0, "R8 duplicate refused");
        accept(8'hA3, 1, 1, "R8 accept A3");
        offer_is(1, 8'hA3, "R2 offer A3 word5");
        accept(8'h21, 0, 1, "R8 accept 21");
        offer_is(1, 8'hA3, "R2 still A3");

        tpr_wr = 1; tpr_wdata = 8'hA0; tick();
        chk(proc_prio == 8'hA0, "R3 ppr=tpr", proc_prio, 8'hA0);
        offer_is(0, 0, "R4 equal class withheld");
        chk(cr_rdata == 4'hA, "R10 read class", cr_rdata, 4'hA);

        tpr_wr = 1; tpr_wdata = 8'h00; tick();
        offer_is(1, 8'hA3, "R4 offered after tpr drop");
        ack = 1; tick();
        chk(proc_prio == 8'hA0, "R5 ppr from isr", proc_prio, 8'hA0);
        offer_is(0, 0, "R5 lower classes withheld");
        ack = 1; tick();
        chk(proc_prio == 8'hA0, "R11 stray ack", proc_prio, 8'hA0);

        cr_wr = 1; cr_wdata = 4'hB; tick();
        chk(proc_prio == 8'hB0, "R10 class write ppr", proc_prio, 8'hB0);
        chk(cr_rdata == 4'hB, "R10 class readback", cr_rdata, 4'hB);
        tpr_wr = 1; tpr_wdata = 8'h10; cr_wr = 1; cr_wdata = 4'hF; tick();
        chk(cr_rdata == 4'h1, "R10 full write wins", cr_rdata, 4'h1);
        chk(proc_prio == 8'hA0, "R3 isr class above tpr", proc_prio, 8'hA0);

        retire(1, 8'hA3, 1);
        chk(proc_prio == 8'h10, "R6 ppr after eoi", proc_prio, 8'h10);
        offer_is(1, 8'h45, "R6 offer 45");
        retire(0, 0, 0);
        chk(proc_prio == 8'h10, "R7 ppr unchanged", proc_prio, 8'h10);
        chk(eoi_valid == 0, "R7 no pulse", eoi_valid, 0);

        ack = 1; tick();
        chk(proc_prio == 8'h40, "R5 ppr 40", proc_prio, 8'h40);
        accept(8'h47, 1, 1, "R8 accept 47");
        offer_is(0, 0, "R4 same class as isr");
        accept(8'h5F, 0, 1, "R8 accept 5F");
        offer_is(1, 8'h5F, "R4 higher class");
        ack = 1; tick();
        chk(proc_prio == 8'h50, "R5 ppr 50", proc_prio, 8'h50);
        retire(1, 8'h5F, 0);
        chk(proc_prio == 8'h40, "R6 nested ppr", proc_prio, 8'h40);
        offer_is(0, 0, "R4 47 still withheld");
        retire(1, 8'h45, 0);
        offer_is(1, 8'h47, "R6 offer 47");

        ack = 1; tick();
        accept(8'h47, 0, 1, "R9 re-accept in service");
        retire(1, 8'h47, 0);
        offer_is(1, 8'h47, "R9 re-pending 47");
        ack = 1; tick();
        retire(1, 8'h47, 0);
        offer_is(1, 8'h21, "R4 class 2 over 10");

        enable = 0; #1;
        offer_is(0, 0, "R4 disabled withholds");
        accept(8'h80, 1, 0, "R8 disabled refused");
        enable = 1; #1;
        offer_is(1, 8'h21, "R8 refused left no bit");
        accept(8'hFF, 0, 1, "R8 accept FF");
        offer_is(1, 8'hFF, "R2 top of word7");

        repeat (3) tick();
        chk(exp_q.size() == 0, "R6 all notifications seen", exp_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule